// File: doc/BRIEF.md
# Packed-Word Palette Loader

A 256-entry color lookup table with 24-bit entries (8 bits each of red, green and blue), loaded from a 32-bit host register port. The host first writes an entry index into the index register, then streams 32-bit words into the data register. Every word carries four color bytes, so entry boundaries do not line up with word boundaries. Four consecutive entries (12 bytes) take exactly three words, and the red, green and blue components rotate through the byte lanes from one word to the next. An internal sequencer tracks which entry and which component the next byte belongs to, and it advances the entry index on its own.

A data-register read returns the next four packed bytes from the current position and advances the sequencer in the same way as a write. Software can therefore change one entry by reading back its aligned group of four as three words, patching the bytes, rewinding the index and writing the three words again. A separate pixel port returns the 24-bit color of an 8-bit pixel index one clock later.

Top module: `palette_pack_loader`

## Requirements
- R1: After reset every table entry is zero, `pix_rgb` is zero and the sequencer points at entry 0, red component.
- R2: A write with `host_sel`=0 loads `host_wdata[7:0]` as the entry index and returns the sequencer to the red component. Pending red or green bytes of an unfinished entry are dropped and that entry keeps its old value.
- R3: A write with `host_sel`=1 consumes its bytes in the order [31:24], [23:16], [15:8], [7:0]. Each byte is the next component in the order red, green, blue, after which the index moves to the next entry. Three words starting at an index that is a multiple of four therefore fill that entry and the next three, with lanes R,G,B,R then G,B,R,G then B,R,G,B.
- R4: An entry changes in the table only when its blue byte arrives, and all 24 bits change at once. Until then the pixel port returns the entry's old color.
- R5: After the blue byte of entry 255 the index wraps to entry 0, red component.
- R6: `pix_rgb` shows table[`pix_idx`] one clock after `pix_idx` is presented, packed as red in [23:16], green in [15:8] and blue in [7:0]. When the pixel read and a host commit hit the same entry in the same cycle, the pixel read returns the old color.
- R7: A read pulse with `host_sel`=1 puts the next four table bytes from the current position on `host_rdata` one clock later, most significant byte first and in the order of R3. It advances the sequencer by four bytes.
- R8: Data reads never modify the table. Rewriting an aligned group with words read back from it, with one entry's bytes patched, changes only that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_sel | input | 1 | Register select: 0 = index register, 1 = data register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Packed word returned by the last data read |
| pix_idx | input | 8 | Pixel index |
| pix_rgb | output | 24 | Color of the pixel index, one clock later |

## Verification
The assertions assume that the host never raises `host_we` and `host_re` in the same cycle. The bench drives each strobe for a single cycle, one access at a time. Given that assumption, the assertions check the following:
- every data access moves the sequencer position forward by exactly four bytes, modulo 768;
- an index write leaves the sequencer on red;
- the table is written only by data writes;
- the pixel output holds steady when neither its index nor the table changed.

The bench programs indices at group boundaries, except in the scenario that resets the sequencer in the middle of a stream on purpose.

// File: rtl/palette_pack_loader.sv
module palette_pack_loader #(
  parameter int IDX_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic        host_re,
  input  logic        host_sel,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic [IDX_W-1:0] pix_idx,
  output logic [23:0] pix_rgb
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int POS_W = IDX_W + 2;
  localparam logic [POS_W-1:0] SPAN = POS_W'(3 * DEPTH);

  logic [23:0]      tab [DEPTH];
  logic [IDX_W-1:0] ent;
  logic [1:0]       comp;
  logic [7:0]       hold_r, hold_g;

  logic             idx_wr, dat_wr, dat_rd;
  logic [IDX_W-1:0] nx_ent, a_idx, b_idx;
  logic [1:0]       nx_comp;
  logic [7:0]       nx_hr, nx_hg;
  logic             wr_a, wr_b;
  logic [23:0]      a_val, b_val;
  logic [31:0]      rd_word;

  assign idx_wr = host_we && !host_sel;
  assign dat_wr = host_we && host_sel;
  assign dat_rd = host_re && host_sel && !host_we;

  always_comb begin
    logic [IDX_W-1:0] e;
    logic [1:0]       c;
    logic [7:0]       hr, hg, wb, rb;
    logic [23:0]      cur;
    logic             fa, fb;
    e = ent; c = comp; hr = hold_r; hg = hold_g;
    fa = 1'b0; fb = 1'b0;
    a_idx = '0; b_idx = '0; a_val = '0; b_val = '0;
    rd_word = '0;
    for (int k = 0; k < 4; k++) begin
      wb  = host_wdata[31-8*k -: 8];
      cur = tab[e];
      case (c)
        2'd0:    rb = cur[23:16];
        2'd1:    rb = cur[15:8];
        default: rb = cur[7:0];
      endcase
      rd_word[31-8*k -: 8] = rb;
      if (c == 2'd0) hr = wb;
      else if (c == 2'd1) hg = wb;
      else if (!fa) begin
        fa = 1'b1; a_idx = e; a_val = {hr, hg, wb};
      end else begin
        fb = 1'b1; b_idx = e; b_val = {hr, hg, wb};
      end
      if (c == 2'd2) begin
        e = e + 1'b1;
        c = 2'd0;
      end else begin
        c = c + 2'd1;
      end
    end
    nx_ent = e; nx_comp = c; nx_hr = hr; nx_hg = hg;
    wr_a = fa && dat_wr;
    wr_b = fb && dat_wr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent <= '0;
      comp <= 2'd0;
      hold_r <= '0;
      hold_g <= '0;
      host_rdata <= '0;
      pix_rgb <= '0;
      for (int i = 0; i < DEPTH; i++) tab[i] <= '0;
    end else begin
      pix_rgb <= tab[pix_idx];
      if (idx_wr) begin
        ent  <= host_wdata[IDX_W-1:0];
        comp <= 2'd0;
      end else if (dat_wr || dat_rd) begin
        ent  <= nx_ent;
        comp <= nx_comp;
        if (dat_wr) begin
          hold_r <= nx_hr;
          hold_g <= nx_hg;
        end
        if (dat_rd) host_rdata <= rd_word;
      end
      if (wr_a) tab[a_idx] <= a_val;
      if (wr_b) tab[b_idx] <= b_val;
    end
  end

  logic [POS_W-1:0] pos;
  assign pos = POS_W'(ent) * POS_W'(3) + POS_W'(comp);

  a_host_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_we && host_re));

  a_r3_word_four_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr || dat_rd) |=> pos == (($past(pos) >= SPAN - POS_W'(4)) ?
                                   $past(pos) - (SPAN - POS_W'(4)) : $past(pos) + POS_W'(4)));

  a_r2_index_to_red: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> comp == 2'd0 && ent == $past(host_wdata[IDX_W-1:0]));

  a_r3_comp_range: assert property (@(posedge clk) disable iff (!rst_n)
    comp != 2'd3);

  a_r8_no_commit_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_wr |-> !wr_a && !wr_b);

  a_r6_pix_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_a && !wr_b) && $stable(pix_idx)) |=> $stable(pix_rgb));
endmodule

// File: tb/sim_palette_pack_loader.sv
module sim_palette_pack_loader;
  logic clk = 0, rst_n = 0;
  logic host_we = 0, host_re = 0, host_sel = 0;
  logic [31:0] host_wdata = 0;
  logic [31:0] host_rdata;
  logic [7:0]  pix_idx = 0;
  logic [23:0] pix_rgb;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [23:0] m_tab [256];
  logic [7:0]  m_ent;
  int          m_comp;
  logic [7:0]  m_hr, m_hg;

  palette_pack_loader u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic m_wr_byte(input logic [7:0] b);
    if (m_comp == 0) m_hr = b;
    else if (m_comp == 1) m_hg = b;
    else m_tab[m_ent] = {m_hr, m_hg, b};
    if (m_comp == 2) begin m_comp = 0; m_ent = m_ent + 1; end
    else m_comp++;
  endtask

  function automatic logic [7:0] m_byte_at(input logic [7:0] e, input int c);
    return (c == 0) ? m_tab[e][23:16] : (c == 1) ? m_tab[e][15:8] : m_tab[e][7:0];
  endfunction

  task automatic set_index(input logic [7:0] idx);
    @(negedge clk);
    host_sel = 0; host_we = 1; host_wdata = {24'h0, idx};
    @(negedge clk);
    host_we = 0;
    m_ent = idx; m_comp = 0;
  endtask

  task automatic put_word(input logic [31:0] w);
    @(negedge clk);
    host_sel = 1; host_we = 1; host_wdata = w;
    @(negedge clk);
    host_we = 0;
    for (int k = 0; k < 4; k++) m_wr_byte(w[31-8*k -: 8]);
  endtask

  task automatic get_word(input string req, output logic [31:0] w);
    logic [31:0] exp;
    for (int k = 0; k < 4; k++) begin
      exp[31-8*k -: 8] = m_byte_at(m_ent, m_comp);
      if (m_comp == 2) begin m_comp = 0; m_ent = m_ent + 1; end
      else m_comp++;
    end
    @(negedge clk);
    host_sel = 1; host_re = 1;
    @(negedge clk);
    host_re = 0;
    w = host_rdata;
    chk(req, w, exp);
  endtask

  task automatic peek(input string req, input logic [7:0] idx, input logic [23:0] exp);
    @(negedge clk);
    pix_idx = idx;
    @(negedge clk);
    chk(req, {8'h0, pix_rgb}, {8'h0, exp});
  endtask

  task automatic t_reset;
    chk("R1 pix_rgb after reset", {8'h0, pix_rgb}, 32'h0);
    peek("R1 entry 0", 8'd0, 24'h0);
    peek("R1 entry 255", 8'd255, 24'h0);
  endtask

  task automatic t_group;
    set_index(8'd0);
    put_word(32'h11223344);
    put_word(32'h55667788);
    put_word(32'h99AABBCC);
    peek("R3 entry 0", 8'd0, 24'h112233);
    peek("R3 entry 1", 8'd1, 24'h445566);
    peek("R3 entry 2", 8'd2, 24'h778899);
    peek("R3 entry 3", 8'd3, 24'hAABBCC);
  endtask

  task automatic t_partial;
    set_index(8'd8);
    put_word(32'hA1A2A3A4);
    peek("R4 entry 8 done", 8'd8, 24'hA1A2A3);
    peek("R4 entry 9 still old", 8'd9, 24'h0);
    put_word(32'hB1B2B3B4);
    peek("R4 entry 9 done", 8'd9, 24'hA4B1B2);
    peek("R4 entry 10 still old", 8'd10, 24'h0);
  endtask

  task automatic t_wrap;
    set_index(8'd252);
    put_word(32'h01020304);
    put_word(32'h05060708);
    put_word(32'h090A0B0C);
    peek("R5 entry 255", 8'd255, 24'h0A0B0C);
    put_word(32'hC0C1C2C3);
    peek("R5 wrap to entry 0", 8'd0, 24'hC0C1C2);
    peek("R5 entry 1 untouched", 8'd1, m_tab[1]);
  endtask

  task automatic t_index_reset;
    set_index(8'd16);
    put_word(32'hD0D1D2D3);
    set_index(8'd20);
    put_word(32'hE0E1E2E3);
    peek("R2 entry 20 starts at red", 8'd20, 24'hE0E1E2);
    peek("R2 entry 17 dropped", 8'd17, 24'h0);
    peek("R2 entry 16 kept", 8'd16, 24'hD0D1D2);
  endtask

  task automatic t_readback;
    logic [31:0] w;
    set_index(8'd0);
    get_word("R7 read word 0", w);
    chk("R7 word 0 value", w, 32'hC0C1C244);
    get_word("R7 read word 1", w);
    get_word("R7 read word 2", w);
    chk("R7 word 2 value", w, 32'h99AABBCC);
    peek("R8 entry 2 after reads", 8'd2, 24'h778899);
    put_word(32'h7172737F);
    peek("R7 sequencer moved to entry 4", 8'd4, 24'h717273);
  endtask

  task automatic t_single_update;
    logic [31:0] w0, w1, w2;
    logic [23:0] e4, e6, e7;
    set_index(8'd4);
    put_word(32'h41424344);
    put_word(32'h45464748);
    put_word(32'h494A4B4C);
    e4 = 24'h414243; e6 = 24'h474849; e7 = 24'h4A4B4C;
    set_index(8'd4);
    get_word("R8 group read 0", w0);
    get_word("R8 group read 1", w1);
    get_word("R8 group read 2", w2);
    w0[7:0] = 8'hF1;
    w1[31:16] = 16'hF2F3;
    set_index(8'd4);
    put_word(w0);
    put_word(w1);
    put_word(w2);
    peek("R8 entry 5 patched", 8'd5, 24'hF1F2F3);
    peek("R8 entry 4 unchanged", 8'd4, e4);
    peek("R8 entry 6 unchanged", 8'd6, e6);
    peek("R8 entry 7 unchanged", 8'd7, e7);
  endtask

  task automatic t_collision;
    set_index(8'd40);
    @(negedge clk);
    pix_idx = 8'd40;
    host_sel = 1; host_we = 1; host_wdata = 32'h5A5B5C5D;
    @(negedge clk);
    host_we = 0;
    for (int k = 0; k < 4; k++) m_wr_byte(host_wdata[31-8*k -: 8]);
    chk("R6 collision returns old", {8'h0, pix_rgb}, 32'h0);
    @(negedge clk);
    chk("R6 new color next cycle", {8'h0, pix_rgb}, 32'h005A5B5C);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) m_tab[i] = '0;
    m_ent = 0; m_comp = 0; m_hr = 0; m_hg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_group;
    t_partial;
    t_wrap;
    t_index_reset;
    t_readback;
    t_single_update;
    t_collision;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule